// File: doc/BRIEF.md
# Protected Work-RAM Write Gate

This block puts a byte-wide work RAM behind a CPU bus and filters every store. A lock register decides whether protection is in force. Protection is lifted only while that register holds the unlock code 0xB4. Any other value, including its reset value, keeps protection on. A mask register names the guarded locations: a location is guarded when every bit set in the mask is also set in its address. While protection is on, a store to a guarded location is discarded. The block raises a one-cycle violation flag and keeps the offending address for debug. Loads are never filtered.

The mask register is itself behind the same lock. Software writes the unlock code, reprograms the mask, then writes any other value to lock again. At reset the mask is all ones across the address width, so that pattern lies past the end of the array and nothing is guarded. The array depth is a parameter: a 12 KB map at addresses 0x0000 to 0x2FFF uses `ADDR_W=14` and `DEPTH=12288`. Addresses at or above `DEPTH` are not backed by storage.

Top module: `prot_ram_gate`

## Requirements
- R1: After reset `locked` is 1, `viol` is 0, and the mask is all ones over `ADDR_W` bits, so a store to any in-range address completes.
- R2: A configuration write with `cfg_sel`=0 sets `locked` to 0 when `cfg_wdata[7:0]` is 0xB4 and to 1 for any other value, from the next cycle on.
- R3: While `locked` is 1, a store whose address satisfies (address AND mask) == mask leaves the RAM contents unchanged.
- R4: While `locked` is 1, a store whose address does not satisfy the mask test is written to the RAM.
- R5: While `locked` is 0, every in-range store is written, matching addresses included, and `viol` stays 0.
- R6: A configuration write with `cfg_sel`=1 loads the mask from `cfg_wdata` only while `locked` is 0. While `locked` is 1 it is ignored.
- R7: A load (`bus_re`=1) gives `bus_rvalid`=1 and the addressed byte on `bus_rdata` in the next cycle, whatever the lock state. Loads can be issued every cycle.
- R8: A discarded store sets `viol` to 1 for exactly the following cycle, and `viol_addr` then holds its address until the next discarded store.
- R9: A store to an address at or above `DEPTH` changes nothing and never raises `viol`. A load there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the load or store |
| bus_we | input | 1 | Store strobe |
| bus_wdata | input | DATA_W | Store data |
| bus_re | input | 1 | Load strobe |
| bus_rdata | output | DATA_W | Load data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Load result valid, one cycle after bus_re |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the lock register, 1 selects the mask register |
| cfg_wdata | input | ADDR_W | Configuration write data; the lock register uses bits 7:0 |
| locked | output | 1 | 1 while protection is in force |
| viol | output | 1 | One-cycle pulse after a discarded store |
| viol_addr | output | ADDR_W | Address of the latest discarded store |

## Verification
The bench builds the block with `ADDR_W=12` and `DEPTH=3072`, a quarter-scale copy of the 12 KB map. Because the array is not a power of two deep, the reset mask 0xFFF and the band 0xC00 to 0xFFF lie past the last cell at 0xBFF. This makes the out-of-range path reachable, including an address that meets the mask test but has no storage behind it. A 12-bit address is also wide enough for masks with several set bits, so one mask guards scattered locations that the bench can probe on both sides of the match.

// File: rtl/prot_ram_pkg.sv
package prot_ram_pkg;
  localparam logic [7:0] UNLOCK_CODE = 8'hB4;

  typedef enum logic {
    SEL_LOCK = 1'b0,
    SEL_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/prot_regs.sv
module prot_regs
  import prot_ram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              locked_q,
  output logic [ADDR_W-1:0] mask_q
);
  logic wr_lock;
  logic wr_mask;

  assign wr_lock = cfg_we && (cfg_sel == SEL_LOCK);
  assign wr_mask = cfg_we && (cfg_sel == SEL_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
    end else if (wr_lock) begin
      locked_q <= (cfg_wdata[7:0] != UNLOCK_CODE);
    end
  end

  // Mask only changes while the lock is open.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_mask && !locked_q) begin
      mask_q <= cfg_wdata;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (locked_q && (mask_q == '1)));

  p_relock_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && (cfg_wdata[7:0] != UNLOCK_CODE)) |=> locked_q);

  p_unlock_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && (cfg_wdata[7:0] == UNLOCK_CODE)) |=> !locked_q);

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !wr_lock) |=> $stable(mask_q));
endmodule

// File: rtl/wr_gate.sv
module wr_gate #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 3072
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              locked,
  input  logic [ADDR_W-1:0] mask,
  output logic              ram_we,
  output logic              viol_q,
  output logic [ADDR_W-1:0] viol_addr_q
);
  localparam logic [ADDR_W:0] LIMIT = ADDR_W'(DEPTH) == 0 ? '1 : (ADDR_W+1)'(DEPTH);

  logic in_range;
  logic hit;
  logic blocked;

  assign in_range = {1'b0, bus_addr} < LIMIT;
  assign hit      = (bus_addr & mask) == mask;
  assign blocked  = bus_we && in_range && locked && hit;
  assign ram_we   = bus_we && in_range && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q      <= 1'b0;
      viol_addr_q <= '0;
    end else begin
      viol_q <= blocked;
      if (blocked) viol_addr_q <= bus_addr;
    end
  end

  p_drop_no_store_r3: assert property (@(posedge clk) disable iff (rst)
    viol_q |-> !$past(ram_we));

  p_pass_unmatched_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && in_range && !hit) |-> ram_we);

  p_open_no_viol_r5: assert property (@(posedge clk) disable iff (rst)
    viol_q |-> $past(locked));

  p_viol_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !viol_q |-> $stable(viol_addr_q));

  p_oob_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    viol_q |-> ({1'b0, $past(bus_addr)} < LIMIT));
endmodule

// File: rtl/ram_array.sv
module ram_array #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 3072,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              in_q;
  logic              in_range;

  assign in_range = {1'b0, addr} < LIMIT;

  // Plain single-port array, no reset, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re && in_range) rd_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      in_q   <= 1'b0;
    end else begin
      rvalid <= re;
      in_q   <= in_range;
    end
  end

  assign rdata = in_q ? rd_q : '0;

  p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);

  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rvalid);
endmodule

// File: rtl/prot_ram_gate.sv
module prot_ram_gate #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 3072,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              locked,
  output logic              viol,
  output logic [ADDR_W-1:0] viol_addr
);
  logic [ADDR_W-1:0] mask;
  logic              ram_we;

  prot_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .locked_q  (locked),
    .mask_q    (mask)
  );

  wr_gate #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .locked      (locked),
    .mask        (mask),
    .ram_we      (ram_we),
    .viol_q      (viol),
    .viol_addr_q (viol_addr)
  );

  ram_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (ram_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .re     (bus_re),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  p_viol_needs_lock_r3: assert property (@(posedge clk) disable iff (rst)
    viol |-> ($past(locked) && $past(bus_we)));
endmodule

// File: tb/prot_ram_gate_bench.sv
module prot_ram_gate_bench;
  localparam int AW = 12;
  localparam int DP = 3072;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          locked;
  logic          viol;
  logic [AW-1:0] viol_addr;

  always #5 clk = ~clk;

  prot_ram_gate #(.ADDR_W(AW), .DEPTH(DP), .DATA_W(DW)) u_prot_ram_gate (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .locked(locked), .viol(viol), .viol_addr(viol_addr)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model built from the requirements.
  logic [DW-1:0] mdl [DP];
  bit            m_locked = 1'b1;
  logic [AW-1:0] m_mask   = '1;

  logic [DW-1:0] q_exp [$];
  string         q_req [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input logic [AW-1:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!sel) m_locked = (d[7:0] != 8'hB4);
    else if (!m_locked) m_mask = d;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    bit inr;
    bit blk;
    inr = (int'(a) < DP);
    blk = inr && m_locked && ((a & m_mask) == m_mask);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    if (inr && !blk) mdl[a] = d;
    @(negedge clk);
    check(viol == blk, req, "viol after store", int'(viol), int'(blk));
    if (blk) check(viol_addr == a, req, "viol_addr", int'(viol_addr), int'(a));
    @(negedge clk);
    check(viol == 1'b0, "R8", "viol single cycle", int'(viol), 0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    @(posedge clk); #1;
    bus_re = 1'b1; bus_addr = a;
    q_exp.push_back((int'(a) < DP) ? mdl[a] : '0);
    q_req.push_back(req);
    @(posedge clk); #1;
    bus_re = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops expected load data as results appear.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R7", "unexpected rvalid", 1, 0);
      end else begin
        logic [DW-1:0] e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        check(bus_rdata == e, r, "load data", int'(bus_rdata), int'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(locked == 1'b1, "R1", "locked after reset", int'(locked), 1);
    check(viol == 1'b0, "R1", "viol after reset", int'(viol), 0);

    // R1/R4: reset mask guards nothing in range
    wr(12'h000, 8'h11, "R1");
    wr(12'hBFF, 8'h22, "R1");
    wr(12'h300, 8'h33, "R4");
    wr(12'h7F3, 8'h44, "R4");
    wr(12'h100, 8'h55, "R4");
    wr(12'h001, 8'h66, "R4");
    rd(12'h000, "R1");
    rd(12'hBFF, "R1");

    // R6: mask write ignored while locked
    cfg(1'b1, 12'h800);
    wr(12'h800, 8'h77, "R6");
    rd(12'h800, "R6");

    // R2: wrong code keeps lock, right code opens it
    cfg(1'b0, 12'h012);
    @(negedge clk);
    check(locked == 1'b1, "R2", "locked after wrong code", int'(locked), 1);
    cfg(1'b0, 12'h0B4);
    @(negedge clk);
    check(locked == 1'b0, "R2", "locked after unlock code", int'(locked), 0);

    // R5: unlocked, matching store completes
    cfg(1'b1, 12'h300);
    wr(12'h300, 8'h88, "R5");
    wr(12'h7F3, 8'h99, "R5");
    rd(12'h300, "R5");

    // R2: any other value relocks; upper cfg bits do not matter
    cfg(1'b0, 12'hFB5);
    @(negedge clk);
    check(locked == 1'b1, "R2", "relock with 0xB5", int'(locked), 1);

    // R3/R8: guarded stores dropped
    wr(12'h300, 8'hA1, "R3");
    wr(12'h7F3, 8'hA2, "R3");
    @(negedge clk);
    check(viol_addr == 12'h7F3, "R8", "viol_addr held", int'(viol_addr), 12'h7F3);
    wr(12'h100, 8'hA3, "R4");
    check(viol_addr == 12'h7F3, "R8", "viol_addr kept after clean store",
          int'(viol_addr), 12'h7F3);
    rd(12'h300, "R3");
    rd(12'h7F3, "R3");
    rd(12'h100, "R7");

    // R6: mask change attempt while locked leaves old mask in force
    cfg(1'b1, 12'h001);
    wr(12'h001, 8'hB1, "R6");
    wr(12'h301, 8'hB2, "R6");
    rd(12'h001, "R6");

    // R9: out of range, including a mask hit past the array
    wr(12'hF00, 8'hC1, "R9");
    wr(12'hC00, 8'hC2, "R9");
    rd(12'hF00, "R9");
    rd(12'hFFF, "R9");

    // R7: back-to-back loads over a written pattern while locked
    cfg(1'b0, 12'h0B4);
    for (int i = 0; i < 16; i++) wr(AW'(12'h400 + i * 5), DW'(i * 17 + 3), "R5");
    cfg(1'b0, 12'h000);
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) begin
      bus_re = 1'b1;
      bus_addr = AW'(12'h400 + i * 5);
      q_exp.push_back(mdl[12'h400 + i * 5]);
      q_req.push_back("R7");
      @(posedge clk); #1;
    end
    bus_re = 1'b0;
    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R7", "loads left unanswered", q_exp.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule